// File: doc/BRIEF.md
# Enable-Guarded Serial Port Configuration Register File

This block is the software-facing configuration store of a serial port controller. A register bus reads and writes three 32-bit words: a primary control word, a secondary control word and a bit-rate divisor word. The block decodes their fields into plain configuration pins for a downstream serial engine. While the port is switched on, or is switching on, writes to the configuration fields are dropped, so the serial engine never sees its setup change under it. While the port is switching off, those writes are kept in a single pending slot and committed at the moment the port reaches the off state.

Turning the port on or off, and the self-clear sequence, each take `SYNC_CYCLES` core-clock cycles. A busy pin reports that time. The bus request channel uses valid/ready. `req_ready` is tied high, so every request is taken in the cycle `req_valid` is high and the bus never sees back-pressure. A read answers one cycle later on `rsp_valid`/`rsp_rdata`. That response has no ready signal and cannot be stalled.

Top module: `serial_cfg_regs`

## Requirements
- R1: After reset all three words read 0, `sync_busy`, `port_on`, `rx_en` and `tx_en` are 0, and `req_ready` is 1.
- R2: While the port is off and not busy, a write updates the guarded bits of the addressed word, only in byte lanes whose `req_strb` bit is set. Word index 0 is the primary word, 1 the secondary word and 2 the divisor word (guarded bits [15:0]). A read accepted in one cycle returns the word in the next cycle with `rsp_valid` high.
- R3: Writing 1 to primary bit 1 (on/off) while the port is off raises `sync_busy` for exactly `SYNC_CYCLES` cycles, after which `port_on` is 1. Bit 1 reads back the written value at once.
- R4: While switching on or while on, writes to guarded bits are discarded.
- R5: Writing 0 to primary bit 1 while the port is on clears `port_on` at once and holds `sync_busy` for `SYNC_CYCLES` cycles.
- R6: A guarded write made while switching off is not visible in reads until switching off completes, and it is then committed.
- R7: One write is held pending. A second pending write to the same word merges with it per byte lane, the newer lane winning. A pending write to a different word replaces it.
- R8: Secondary bits 16 (receiver enable) and 17 (transmitter enable) take effect on any write with strobe lane 2, in every state except self-clear.
- R9: Writing 1 to primary bit 0 while not busy starts a self-clear that lasts `SYNC_CYCLES` busy cycles. After it, every word reads 0, and bit 0 reads 0 again.
- R10: Decoded pins: `clk_internal` is 1 when primary bits [4:2] equal 1 (0 selects the external clock). `sync_mode` is primary bit 7 (0 means asynchronous). `rx_pad` is bits [17:16] and `tx_pad` is bits [21:20]. `parity_en` is 1 when bits [27:24] equal 1, and `msb_first` is bit 30. From the secondary word, `char_size` is bits [2:0], `two_stop` is bit 6 and `parity_odd` is bit 13. `baud` is the divisor word's bits [15:0].
- R11: Writes to primary bits 0 and 1 are ignored while `sync_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word index |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte-lane write strobes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| port_on | output | 1 | Port fully on |
| sync_busy | output | 1 | On/off or self-clear sequence running |
| clk_internal | output | 1 | Internal clock selected |
| sync_mode | output | 1 | Synchronous communication |
| rx_pad | output | 2 | Receive pad select |
| tx_pad | output | 2 | Transmit pad select |
| parity_en | output | 1 | Parity frames |
| parity_odd | output | 1 | Odd parity |
| two_stop | output | 1 | Two stop bits |
| msb_first | output | 1 | Most significant bit first |
| char_size | output | 3 | Character size code |
| baud | output | 16 | Bit-rate divisor |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |

## Verification
The guard is tried with the same kind of write in four states: off, switching on, on, and switching off. Only the off state may commit at once, and only switching off may commit later. Partial-strobe writes to the divisor, in the off state and then as two pending writes, separate per-lane merging from whole-word overwrite. A pending write to one word followed by one to another shows replacement, and the busy-cycle counts for switching on and for self-clear expose any off-by-one in the sequencer. Writes to the on/off and self-clear bits made mid-sequence, and receiver/transmitter toggles made while the port is on, show which bits escape the guard.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned SW = DW / 8;
  localparam int unsigned AW = 2;

  typedef enum logic [2:0] {
    ST_OFF, ST_ENABLING, ST_ON, ST_DISABLING, ST_RESETTING
  } scfg_state_e;

  localparam logic [AW-1:0] ADDR_PRI  = 2'd0;
  localparam logic [AW-1:0] ADDR_SEC  = 2'd1;
  localparam logic [AW-1:0] ADDR_BAUD = 2'd2;

  localparam int unsigned BIT_CLR = 0;
  localparam int unsigned BIT_ON  = 1;

  localparam logic [DW-1:0] GUARD_PRI  = 32'h4F33_009C;
  localparam logic [DW-1:0] GUARD_SEC  = 32'h0000_2047;
  localparam logic [DW-1:0] FREE_SEC   = 32'h0003_0000;
  localparam logic [DW-1:0] GUARD_BAUD = 32'h0000_FFFF;

  function automatic logic [DW-1:0] lane_bits(input logic [SW-1:0] s);
    logic [DW-1:0] m;
    for (int i = 0; i < SW; i++) m[i*8 +: 8] = {8{s[i]}};
    return m;
  endfunction

  function automatic logic [DW-1:0] blend(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [DW-1:0] m);
    return (old_w & ~m) | (new_w & m);
  endfunction
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync import scfg_pkg::*; #(
  parameter int unsigned SYNC_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_en,
  input  logic        go_dis,
  input  logic        go_rst,
  output scfg_state_e st_o,
  output logic        done_o
);
  localparam int unsigned CW = $clog2(SYNC_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(SYNC_CYCLES - 1);

  scfg_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic busy;

  assign busy   = (st_q == ST_ENABLING) || (st_q == ST_DISABLING) || (st_q == ST_RESETTING);
  assign done_o = busy && (cnt_q == '0);
  assign st_o   = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == '0) begin
        st_q <= (st_q == ST_ENABLING) ? ST_ON : ST_OFF;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (go_rst) begin
      st_q  <= ST_RESETTING;
      cnt_q <= LOAD;
    end else if (go_en) begin
      st_q  <= ST_ENABLING;
      cnt_q <= LOAD;
    end else if (go_dis) begin
      st_q  <= ST_DISABLING;
      cnt_q <= LOAD;
    end
  end
endmodule

// File: rtl/scfg_defer.sv
module scfg_defer import scfg_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_disabling,
  input  logic          take,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [SW-1:0] strb,
  input  logic          drop,
  output logic          m_valid,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_data,
  output logic [SW-1:0] m_strb
);
  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [SW-1:0] strb_q;
  logic          same;

  assign same = pend_q && (addr_q == addr);

  for (genvar g = 0; g < SW; g++) begin : g_lane
    always_comb begin
      if (take && !(same && !strb[g])) begin
        m_data[g*8 +: 8] = data[g*8 +: 8];
        m_strb[g]        = strb[g];
      end else begin
        m_data[g*8 +: 8] = data_q[g*8 +: 8];
        m_strb[g]        = take ? 1'b0 : strb_q[g];
      end
      if (take && same && !strb[g]) m_strb[g] = strb_q[g];
    end
  end

  assign m_valid = pend_q || take;
  assign m_addr  = take ? addr : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      strb_q <= '0;
    end else if (drop) begin
      pend_q <= 1'b0;
      strb_q <= '0;
    end else if (take) begin
      pend_q <= 1'b1;
      addr_q <= m_addr;
      data_q <= m_data;
      strb_q <= m_strb;
    end
  end

  AST_PEND_IN_DISABLING: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> in_disabling); // R6
endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs import scfg_pkg::*; #(
  parameter int unsigned SYNC_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [SW-1:0] req_strb,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          port_on,
  output logic          sync_busy,
  output logic          clk_internal,
  output logic          sync_mode,
  output logic [1:0]    rx_pad,
  output logic [1:0]    tx_pad,
  output logic          parity_en,
  output logic          parity_odd,
  output logic          two_stop,
  output logic          msb_first,
  output logic [2:0]    char_size,
  output logic [15:0]   baud,
  output logic          rx_en,
  output logic          tx_en
);
  scfg_state_e st;
  logic sync_done, wr_fire, rd_fire, is_pri, is_sec, is_baud;
  logic ctl_wr, rst_req, en_req, dis_req, dis_done, rst_done;
  logic en_q;
  logic [DW-1:0] pri_q, sec_q, baud_q, wmask, rd_word;
  logic          m_valid;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data, m_mask;
  logic [SW-1:0] m_strb;

  assign req_ready = 1'b1;
  assign wr_fire   = req_valid && req_write;
  assign rd_fire   = req_valid && !req_write;
  assign is_pri    = (req_addr == ADDR_PRI);
  assign is_sec    = (req_addr == ADDR_SEC);
  assign is_baud   = (req_addr == ADDR_BAUD);
  assign sync_busy = (st == ST_ENABLING) || (st == ST_DISABLING) || (st == ST_RESETTING);

  assign ctl_wr  = wr_fire && is_pri && req_strb[0] && !sync_busy;
  assign rst_req = ctl_wr && req_wdata[BIT_CLR];
  assign en_req  = ctl_wr && !req_wdata[BIT_CLR] && req_wdata[BIT_ON] && !en_q;
  assign dis_req = ctl_wr && !req_wdata[BIT_CLR] && !req_wdata[BIT_ON] && en_q;

  assign dis_done = sync_done && (st == ST_DISABLING);
  assign rst_done = sync_done && (st == ST_RESETTING);
  assign wmask    = lane_bits(req_strb);
  assign m_mask   = lane_bits(m_strb);

  scfg_sync #(.SYNC_CYCLES(SYNC_CYCLES)) sync_i (
    .clk(clk), .rst_n(rst_n), .go_en(en_req), .go_dis(dis_req), .go_rst(rst_req),
    .st_o(st), .done_o(sync_done)
  );

  scfg_defer defer_i (
    .clk(clk), .rst_n(rst_n), .in_disabling(st == ST_DISABLING),
    .take(wr_fire && (st == ST_DISABLING)), .addr(req_addr), .data(req_wdata),
    .strb(req_strb), .drop(dis_done || rst_done),
    .m_valid(m_valid), .m_addr(m_addr), .m_data(m_data), .m_strb(m_strb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pri_q  <= '0;
      sec_q  <= '0;
      baud_q <= '0;
    end else if (rst_done) begin
      en_q   <= 1'b0;
      pri_q  <= '0;
      sec_q  <= '0;
      baud_q <= '0;
    end else begin
      if (en_req)  en_q <= 1'b1;
      if (dis_req) en_q <= 1'b0;
      if (wr_fire && (st == ST_OFF) && !rst_req) begin
        if (is_pri)  pri_q  <= blend(pri_q,  req_wdata, wmask & GUARD_PRI);
        if (is_sec)  sec_q  <= blend(sec_q,  req_wdata, wmask & (GUARD_SEC | FREE_SEC));
        if (is_baud) baud_q <= blend(baud_q, req_wdata, wmask & GUARD_BAUD);
      end else begin
        if (dis_done && m_valid) begin
          if (m_addr == ADDR_PRI)  pri_q  <= blend(pri_q,  m_data, m_mask & GUARD_PRI);
          if (m_addr == ADDR_BAUD) baud_q <= blend(baud_q, m_data, m_mask & GUARD_BAUD);
        end
        if (wr_fire && is_sec && req_strb[2] && (st != ST_RESETTING)) begin
          if (dis_done && m_valid && (m_addr == ADDR_SEC))
            sec_q <= blend(blend(sec_q, m_data, m_mask & GUARD_SEC), req_wdata, FREE_SEC);
          else
            sec_q <= blend(sec_q, req_wdata, FREE_SEC);
        end else if (dis_done && m_valid && (m_addr == ADDR_SEC)) begin
          sec_q <= blend(sec_q, m_data, m_mask & GUARD_SEC);
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (req_addr)
      ADDR_PRI: begin
        rd_word = pri_q;
        rd_word[BIT_ON]  = en_q;
        rd_word[BIT_CLR] = (st == ST_RESETTING);
      end
      ADDR_SEC:  rd_word = sec_q;
      ADDR_BAUD: rd_word = baud_q;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= rd_word;
    end
  end

  assign port_on      = (st == ST_ON);
  assign clk_internal = (pri_q[4:2] == 3'd1);
  assign sync_mode    = pri_q[7];
  assign rx_pad       = pri_q[17:16];
  assign tx_pad       = pri_q[21:20];
  assign parity_en    = (pri_q[27:24] == 4'd1);
  assign msb_first    = pri_q[30];
  assign char_size    = sec_q[2:0];
  assign two_stop     = sec_q[6];
  assign parity_odd   = sec_q[13];
  assign rx_en        = sec_q[16];
  assign tx_en        = sec_q[17];
  assign baud         = baud_q[15:0];

  AST_GUARD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_ON) || (st == ST_ENABLING)) |=>
      ($stable(pri_q) && $stable(baud_q) && $stable(sec_q & GUARD_SEC))); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> (pri_q == '0 && sec_q == '0 && baud_q == '0 && !en_q)); // R9
  AST_RXTX_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && is_sec && req_strb[2] && (st != ST_RESETTING)) |=>
      ({tx_en, rx_en} == $past(req_wdata[17:16]))); // R8
  AST_ON_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (((st == ST_ENABLING) || (st == ST_DISABLING)) && !sync_done) |=> $stable(en_q)); // R11
endmodule

// File: tb/serial_cfg_regs_tb_top.sv
module serial_cfg_regs_tb_top;
  localparam int unsigned SYNC = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_strb = '0;
  logic req_ready, rsp_valid, port_on, sync_busy, clk_internal, sync_mode;
  logic [31:0] rsp_rdata;
  logic [1:0] rx_pad, tx_pad;
  logic parity_en, parity_odd, two_stop, msb_first, rx_en, tx_en;
  logic [2:0] char_size;
  logic [15:0] baud;
  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_cfg_regs #(.SYNC_CYCLES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .port_on(port_on), .sync_busy(sync_busy),
    .clk_internal(clk_internal), .sync_mode(sync_mode), .rx_pad(rx_pad), .tx_pad(tx_pad),
    .parity_en(parity_en), .parity_odd(parity_odd), .two_stop(two_stop),
    .msb_first(msb_first), .char_size(char_size), .baud(baud), .rx_en(rx_en), .tx_en(tx_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_strb = s;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_strb = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (sync_busy && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) check("unexpected response", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", {31'd0, sync_busy}, 0);
    check("R1 port_on", {31'd0, port_on}, 0);
    check("R1 rxtx", {30'd0, tx_en, rx_en}, 0);
    check("R1 ready", {31'd0, req_ready}, 1);
    rd(0, 32'h0, "R1 pri"); rd(1, 32'h0, "R1 sec"); rd(2, 32'h0, "R1 baud");

    wr(0, 32'h4112_0084, 4'hF);
    wr(1, 32'h0000_2045, 4'hF);
    wr(2, 32'h0000_1234, 4'hF);
    wr(2, 32'hFFFF_AB00, 4'b0010);
    rd(0, 32'h4112_0084, "R2 pri"); rd(1, 32'h0000_2045, "R2 sec");
    rd(2, 32'h0000_AB34, "R2 baud lane strobe");
    check("R10 clk_internal", {31'd0, clk_internal}, 1);
    check("R10 sync_mode", {31'd0, sync_mode}, 1);
    check("R10 pads", {28'd0, tx_pad, rx_pad}, 32'h6);
    check("R10 parity", {30'd0, parity_en, parity_odd}, 32'h3);
    check("R10 stop/order", {30'd0, two_stop, msb_first}, 32'h3);
    check("R10 char_size", {29'd0, char_size}, 5);
    check("R10 baud", {16'd0, baud}, 32'hAB34);

    wr(0, 32'h4112_0086, 4'hF);
    check("R3 busy after on", {31'd0, sync_busy}, 1);
    wait_idle(cyc);
    check("R3 busy cycles", cyc, SYNC - 1 + 1);
    check("R3 port_on", {31'd0, port_on}, 1);
    rd(0, 32'h4112_0086, "R3 on bit reads 1");

    wr(2, 32'h0000_7777, 4'hF);
    wr(1, 32'h0003_0000, 4'hF);
    rd(2, 32'h0000_AB34, "R4 baud write dropped while on");
    rd(1, 32'h0003_2045, "R8 rxtx set while on, guarded dropped");
    check("R8 rx/tx pins", {30'd0, tx_en, rx_en}, 3);

    wr(0, 32'h0, 4'hF);
    check("R5 port_on cleared", {31'd0, port_on}, 0);
    check("R5 busy", {31'd0, sync_busy}, 1);
    wr(2, 32'h0000_00CD, 4'b0001);
    wr(2, 32'h0000_EF00, 4'b0010);
    rd(2, 32'h0000_AB34, "R6 pending not visible");
    wait_idle(cyc);
    rd(2, 32'h0000_EFCD, "R7 lanes merged and committed");
    rd(0, 32'h4112_0084, "R4 guarded bits kept on switch-off write");

    wr(0, 32'h4112_0086, 4'hF);
    wr(2, 32'h0000_1111, 4'hF);
    wr(0, 32'h0000_0001, 4'hF);
    wait_idle(cyc);
    check("R11 stays on", {31'd0, port_on}, 1);
    rd(0, 32'h4112_0086, "R11 clear/off ignored while busy");
    rd(2, 32'h0000_EFCD, "R4 dropped while switching on");

    wr(0, 32'h0000_0004, 4'b0001);
    wr(1, 32'h0000_0003, 4'hF);
    check("R8 rxtx cleared while switching off", {30'd0, tx_en, rx_en}, 0);
    wr(2, 32'h0000_0042, 4'b0001);
    wait_idle(cyc);
    rd(1, 32'h0000_2045, "R7 pending replaced");
    rd(2, 32'h0000_EF42, "R7 replacing write committed");

    wr(0, 32'h0000_0001, 4'b0001);
    rd(0, 32'h4112_0085, "R9 clear bit reads 1 while running");
    wait_idle(cyc);
    check("R9 busy cycles", cyc, SYNC - 1);
    rd(0, 32'h0, "R9 pri zero"); rd(1, 32'h0, "R9 sec zero"); rd(2, 32'h0, "R9 baud zero");
    check("R9 pins", {16'd0, baud}, 0);
    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule